// File: doc/BRIEF.md
# Push-Button Serial Gain Sequencer

This block turns a single debounced press of a "send" button into one complete serial programming frame for an amplifier gain register. When the press arrives, the block captures a 6-bit parallel word from switches, a mode select and two channel selects. It then runs a gated serial clock for a fixed number of cycles and shifts the word out one bit per cycle. After the last cycle it stops itself. The serial clock stays low between frames, so the board carries no idle switching.

In load mode the frame is seven serial cycles long. The first cycle is a lead-in, during which the enable lines are already active and the data line is low. The next six cycles carry the word, most significant bit first. In tracking mode the frame is two serial cycles long: the lead-in, then a single up/down bit. That bit is taken from the same input that supplies the top data bit in load mode. The serial clock is a system clock divided by `2*HALF_DIV`. Data moves on falling edges, so the receiver samples it on rising edges.

Top module: `gain_word_sequencer`

## Requirements
- R1: With `busy_o` low, a high `send_i` at a rising system-clock edge starts a frame. `busy_o` is high from that edge onward.
- R2: `sclk_o` is low whenever `busy_o` is low. During a frame it has a period of `2*HALF_DIV` system clocks and starts low.
- R3: With `load_mode_i`=1 at the press, the frame has exactly seven `sclk_o` rising edges. The `sdata_o` values at those edges are 0, then `word_i[5]`, `word_i[4]` and so on down to `word_i[0]`.
- R4: With `load_mode_i`=0 at the press, the frame has exactly two `sclk_o` rising edges. The `sdata_o` values at those edges are 0, then `word_i[5]` (1 = step up, 0 = step down).
- R5: While `busy_o` is high, `sdata_o` changes only in the same cycle as a falling edge of `sclk_o`.
- R6: `en1_o` and `en2_o` equal `ch1_sel_i` and `ch2_sel_i` as captured at the press. They hold that value for the whole frame, including the lead-in cycle, and are low when idle. A frame with neither channel selected still runs, with both enables low.
- R7: `busy_o` stays high for `2*HALF_DIV*7` system clocks in load mode and `2*HALF_DIV*2` in tracking mode. It falls at the edge of the final falling `sclk_o` edge.
- R8: A `send_i` pulse while `busy_o` is high is ignored, including one at the edge where the frame ends. Changes to `word_i`, the selects or the mode during a frame do not alter the frame in progress.
- R9: `mode_o` is high during a load-mode frame and low during a tracking frame and when idle. After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_i | input | 1 | Debounced send press, one or more cycles high |
| load_mode_i | input | 1 | 1 = full word load, 0 = tracking step |
| ch1_sel_i | input | 1 | Select channel 1 for the frame |
| ch2_sel_i | input | 1 | Select channel 2 for the frame |
| word_i | input | 6 | Parallel switch word; bit 5 is also the up/down bit |
| sclk_o | output | 1 | Gated serial clock |
| sdata_o | output | 1 | Serial data, changes on falling `sclk_o` |
| mode_o | output | 1 | Mode line to the receiver |
| en1_o | output | 1 | Channel 1 enable |
| en2_o | output | 1 | Channel 2 enable |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
Two events can land on the same system-clock edge: the self-termination after the final falling serial edge, and a fresh send press. The bench drives `send_i` so that it is sampled exactly at the terminating edge. It then requires `busy_o` to be low on that cycle and on the next, proving the press was dropped rather than starting a new frame. A separate press in the middle of a frame, with the word and selects inverted, must leave the captured bit stream, the enables and the frame length unchanged.

// File: rtl/gain_word_sequencer.sv
module gain_word_sequencer #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_i,
  input  logic       load_mode_i,
  input  logic       ch1_sel_i,
  input  logic       ch2_sel_i,
  input  logic [5:0] word_i,
  output logic       sclk_o,
  output logic       sdata_o,
  output logic       mode_o,
  output logic       en1_o,
  output logic       en2_o,
  output logic       busy_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic          busy_q, phase_q, mode_q, sel1_q, sel2_q;
  logic [2:0]    pos_q;
  logic [5:0]    word_q;
  logic          bit_sel;

  wire       tick     = busy_q && (div_q == DIV_LAST);
  wire [2:0] last_pos = mode_q ? 3'd6 : 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      pos_q   <= 3'd0;
      word_q  <= '0;
      mode_q  <= 1'b0;
      sel1_q  <= 1'b0;
      sel2_q  <= 1'b0;
    end else if (!busy_q) begin
      if (send_i) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        pos_q   <= 3'd0;
        div_q   <= '0;
        word_q  <= word_i;
        mode_q  <= load_mode_i;
        sel1_q  <= ch1_sel_i;
        sel2_q  <= ch2_sel_i;
      end
    end else begin
      div_q <= tick ? '0 : div_q + DW'(1);
      if (tick) begin
        phase_q <= ~phase_q;
        if (phase_q) begin
          pos_q <= pos_q + 3'd1;
          if (pos_q == last_pos) busy_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (pos_q)
      3'd1:    bit_sel = word_q[5];
      3'd2:    bit_sel = word_q[4];
      3'd3:    bit_sel = word_q[3];
      3'd4:    bit_sel = word_q[2];
      3'd5:    bit_sel = word_q[1];
      3'd6:    bit_sel = word_q[0];
      default: bit_sel = 1'b0;
    endcase
  end

  assign sclk_o  = busy_q & phase_q;
  assign sdata_o = busy_q & bit_sel;
  assign mode_o  = busy_q & mode_q;
  assign en1_o   = busy_q & sel1_q;
  assign en2_o   = busy_q & sel2_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/gain_word_sequencer_chk.sv
module gain_word_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic send_i,
  input logic sclk_o,
  input logic sdata_o,
  input logic mode_o,
  input logic en1_o,
  input logic en2_o,
  input logic busy_o
);
  p_start_from_press_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(send_i));

  p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o);

  p_data_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$stable(sdata_o)) |-> $fell(sclk_o));

  p_enables_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en1_o || en2_o || mode_o) |-> busy_o);

  p_frame_lines_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable({en1_o, en2_o, mode_o}));
endmodule

bind gain_word_sequencer gain_word_sequencer_chk u_chk (.*);

// File: tb/tb_gain_word_sequencer.sv
module tb_gain_word_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int NVEC       = 6;
  // {load_mode, ch1, ch2, word[5:0]}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 6'b101101},
    {1'b1, 1'b0, 1'b1, 6'b010011},
    {1'b1, 1'b1, 1'b1, 6'b111111},
    {1'b0, 1'b1, 1'b0, 6'b100000},
    {1'b0, 1'b1, 1'b1, 6'b011111},
    {1'b1, 1'b0, 1'b0, 6'b000001}
  };

  logic clk = 1'b0, rst_n = 1'b0, send_i = 1'b0, load_mode_i = 1'b0;
  logic ch1_sel_i = 1'b0, ch2_sel_i = 1'b0;
  logic [5:0] word_i = '0;
  logic sclk_o, sdata_o, mode_o, en1_o, en2_o, busy_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_word_sequencer #(.HALF_DIV(HALF_DIV)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic m, input logic c1, input logic c2,
                           input logic [5:0] w, input bit mid_poke, input bit end_poke);
    int nbits = m ? 7 : 2;
    int exp_cycles = 2 * HALF_DIV * nbits;
    int cycles = 0, rises = 0, bad_bits = 0, line_bad = 0, first_r = 0, second_r = 0;
    logic prev = 1'b0;
    load_mode_i = m; ch1_sel_i = c1; ch2_sel_i = c2; word_i = w; send_i = 1'b1;
    @(negedge clk);
    send_i = 1'b0;
    check(busy_o == 1'b1, "R1", busy_o, 1);
    if (mid_poke) begin
      word_i = ~w; ch1_sel_i = ~c1; ch2_sel_i = ~c2; load_mode_i = ~m;
    end
    while (busy_o && cycles < 1000) begin
      cycles++;
      if (sclk_o && !prev) begin
        if (rises == 0) first_r = cycles;
        if (rises == 1) second_r = cycles;
        if (rises < nbits) begin
          if (sdata_o != ((rises == 0) ? 1'b0 : w[6 - rises])) bad_bits++;
        end
        rises++;
      end
      if (en1_o != c1 || en2_o != c2 || mode_o != m) line_bad++;
      send_i = (mid_poke && cycles == 3) || (end_poke && cycles == exp_cycles);
      prev = sclk_o;
      @(negedge clk);
    end
    send_i = 1'b0;
    check(rises == nbits, m ? "R3" : "R4", rises, nbits);
    check(bad_bits == 0, m ? "R3" : "R4", bad_bits, 0);
    check(second_r - first_r == 2 * HALF_DIV, "R2", second_r - first_r, 2 * HALF_DIV);
    check(line_bad == 0, "R6", line_bad, 0);
    check(cycles == exp_cycles, "R7", cycles, exp_cycles);
    check({sclk_o, en1_o, en2_o, mode_o} == 4'b0, "R2", {sclk_o, en1_o, en2_o, mode_o}, 0);
    if (end_poke) begin
      check(busy_o == 1'b0, "R8", busy_o, 0);
      @(negedge clk);
      check(busy_o == 1'b0, "R8", busy_o, 0);
    end
    word_i = '0; ch1_sel_i = 1'b0; ch2_sel_i = 1'b0; load_mode_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    send_i = 1'b1; word_i = 6'h3f; load_mode_i = 1'b1; ch1_sel_i = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state, even with a press held during reset
    check({sclk_o, sdata_o, mode_o, en1_o, en2_o, busy_o} == 6'b0, "R9",
          {sclk_o, sdata_o, mode_o, en1_o, en2_o, busy_o}, 0);
    send_i = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_o == 1'b0 && sclk_o == 1'b0, "R2", busy_o, 0);

    for (int i = 0; i < NVEC; i++)
      run_frame(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:0], 1'b0, 1'b0);

    // R9: mode line high inside a load frame, low inside a tracking frame
    load_mode_i = 1'b1; word_i = 6'h15; send_i = 1'b1;
    @(negedge clk); send_i = 1'b0;
    check(mode_o == 1'b1, "R9", mode_o, 1);
    while (busy_o) @(negedge clk);
    load_mode_i = 1'b0; send_i = 1'b1;
    @(negedge clk); send_i = 1'b0;
    check(mode_o == 1'b0, "R9", mode_o, 0);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);

    // R8: press and input changes in mid-frame
    run_frame(1'b1, 1'b1, 1'b0, 6'b110010, 1'b1, 1'b0);
    run_frame(1'b0, 1'b0, 1'b1, 6'b100101, 1'b1, 1'b0);
    // R8: press at the terminating edge
    run_frame(1'b1, 1'b0, 1'b1, 6'b011010, 1'b0, 1'b1);
    run_frame(1'b0, 1'b1, 1'b1, 6'b000000, 1'b0, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule